// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer with Clock Suspend

This block is the read side of a synchronous DRAM data path. It takes a read command together with a starting column and a latency select, waits the chosen column latency (2 or 3 clocks), and then presents a burst of words. For each word it gives the burst index, the column of the word and a data-valid strobe. Burst columns wrap inside an aligned group of `BURST_LEN` columns. The group starts from the low bits of the requested column.

The clock-enable input `cke` can freeze the sequencer while a read is in flight. If `cke` is sampled low on an edge while a read is pending or streaming, the sequencer enters suspend on that edge. That same edge still counts as a normal working edge. From then on the latency count, the burst index and the captured column are held. The data-valid strobe drops, and the command inputs are ignored. If `cke` is sampled high on a later edge, suspend ends on that edge. The burst continues with the word that had not yet been delivered. After every exit from suspend, new commands stay locked out for `T_CKA` edges. Because nothing refreshes the array during suspend, a counter raises `refresh_warn` once a single suspend has lasted `SUSP_LIMIT` clocks.

The controller has four states:
- `ST_IDLE`: no read in flight.
- `ST_LAT`: counting the column latency.
- `ST_BURST`: streaming words.
- `ST_SUSP`: frozen. The state register keeps the state to return to.

Transitions:
- accept: `ST_IDLE` to `ST_LAT`.
- latency done: `ST_LAT` to `ST_BURST`.
- burst done: `ST_BURST` to `ST_IDLE`.
- suspend entry: `ST_LAT` or `ST_BURST` (or an accepting `ST_IDLE`) to `ST_SUSP`. Entry is not taken when the edge ends the burst.
- suspend exit: `ST_SUSP` back to the saved state.

Top module: `sdr_rdburst_susp`

## Requirements
- R1: After reset `word_valid`, `suspended` and `refresh_warn` are 0 and `cmd_ready` is 1.
- R2: A read is taken on an edge where `cmd_rd`=1 and `cmd_ready`=1. `cas_sel`=0 selects latency 2 and `cas_sel`=1 selects latency 3. With `cke` held high, `word_valid` for word 0 is high just before the edge that comes that many edges after the accepting edge.
- R3: A burst delivers `BURST_LEN` (4) words on consecutive working edges. `word_idx` runs 0,1,2,3. `word_col` keeps the start column's upper bits, and its low two bits are (start low two bits + `word_idx`) mod 4.
- R4: When `cke` is sampled low on an edge during latency or burst, and that edge does not deliver the last word, `suspended` is 1 from that edge on. While `cke` stays low, `word_idx`, `word_col` and the remaining latency are held.
- R5: While `suspended`=1, `word_valid` is 0 and `cmd_ready` is 0. Values on `cmd_rd`, `col` and `cas_sel` have no effect on the words that follow or on their timing.
- R6: When `cke` is sampled high on an edge while suspended, `suspended` drops on that edge. `word_valid` returns on the first word not yet delivered (or the remaining latency resumes), so the burst is delayed by exactly the number of suspended edges.
- R7: For `T_CKA` (2) edges after a suspend exit, `cmd_ready` is 0, and a `cmd_rd` on those edges starts no read.
- R8: `refresh_warn` rises on the `SUSP_LIMIT`-th (16th) edge after suspend entry and is 0 whenever `suspended` is 0.
- R9: `cmd_ready` is 1 only when idle, past recovery, and with `cke` sampled high on the previous edge. A `cmd_rd` while `cmd_ready`=0 is ignored.
- R10: `cke` sampled low on the edge that delivers the last word does not suspend. The block goes idle and `cmd_ready` stays 0 until `cke` has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes an in-flight read |
| cmd_rd | input | 1 | Read command request |
| cas_sel | input | 1 | Latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| col | input | COL_W | Starting column of the read |
| cmd_ready | output | 1 | A read request is taken on the next edge |
| word_valid | output | 1 | Current burst word is valid |
| word_idx | output | IDX_W | Burst index of the current word |
| word_col | output | COL_W | Column of the current word |
| suspended | output | 1 | Sequencer is frozen by clock suspend |
| refresh_warn | output | 1 | Current suspend has reached the refresh budget |

## Verification
Suspend entry and word delivery share an edge. When `cke` falls while a word is valid, that edge both consumes the word and freezes the next one. The bench drops `cke` with `word_valid` high at several burst positions, and also in the latency phase and on the final word. It judges each case by which word reappears after exit, by the word's column, and by whether the burst instead ends idle. The recovery lockout can also expire on the edge where a burst suspended on its last word finishes. That case is provoked by holding `cmd_rd` against the lockout, and it is judged by the exact negedge at which `cmd_ready` rises with no burst started.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_BURST,
        ST_SUSP
    } rdsq_state_e;

    // latency select: 0 -> 2 clocks, 1 -> 3 clocks
    function automatic logic [1:0] cas_cycles(input logic sel);
        return sel ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/rdsq_fsm.sv
module rdsq_fsm
    import sdrs_pkg::*;
#(
    parameter int BURST_LEN = 4,
    localparam int IDX_W = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             cas_sel,
    output logic [IDX_W-1:0] idx,
    output logic             in_idle,
    output logic             in_burst,
    output logic             in_susp,
    output logic             susp_exit
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);

    rdsq_state_e      state_q, state_d, ret_q, ret_d, adv_state;
    logic [1:0]       lat_q, lat_d, adv_lat;
    logic [IDX_W-1:0] idx_q, idx_d, adv_idx;

    // what one working edge would do
    always_comb begin
        adv_state = state_q;
        adv_lat   = lat_q;
        adv_idx   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    adv_state = ST_LAT;
                    adv_lat   = cas_cycles(cas_sel) - 2'd1;
                    adv_idx   = '0;
                end
            end
            ST_LAT: begin
                if (lat_q == 2'd1) begin
                    adv_state = ST_BURST;
                    adv_idx   = '0;
                end else begin
                    adv_lat = lat_q - 2'd1;
                end
            end
            ST_BURST: begin
                if (idx_q == IDX_LAST) adv_state = ST_IDLE;
                else                   adv_idx   = idx_q + IDX_W'(1);
            end
            ST_SUSP: begin
                adv_state = ST_SUSP;
            end
        endcase
    end

    // suspend entry / exit wrapped around the working step
    always_comb begin
        state_d = adv_state;
        ret_d   = ret_q;
        lat_d   = adv_lat;
        idx_d   = adv_idx;
        if (state_q == ST_SUSP) begin
            state_d = cke ? ret_q : ST_SUSP;
            lat_d   = lat_q;
            idx_d   = idx_q;
        end else if (!cke && adv_state != ST_IDLE) begin
            state_d = ST_SUSP;
            ret_d   = adv_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            lat_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            lat_q   <= lat_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        idx       = idx_q;
        in_idle   = (state_q == ST_IDLE);
        in_burst  = (state_q == ST_BURST);
        in_susp   = (state_q == ST_SUSP);
        susp_exit = (state_q == ST_SUSP) && cke;
    end

endmodule

// File: rtl/rdsq_colgen.sv
module rdsq_colgen #(
    parameter int COL_W = 8,
    parameter int BURST_LEN = 4,
    localparam int IDX_W = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] col,
    input  logic [IDX_W-1:0] idx,
    output logic [COL_W-1:0] word_col
);

    logic [COL_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= '0;
        else if (start) base_q <= col;
    end

    generate
        if (COL_W > IDX_W) begin : g_upper
            always_comb word_col = {base_q[COL_W-1:IDX_W], base_q[IDX_W-1:0] + idx};
        end else begin : g_flat
            always_comb word_col = base_q + idx;
        end
    endgenerate

endmodule

// File: rtl/rdsq_guard.sv
module rdsq_guard #(
    parameter int T_CKA = 2,
    localparam int REC_W = $clog2(T_CKA + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic in_idle,
    input  logic susp_exit,
    input  logic cmd_rd,
    output logic ready,
    output logic start
);

    logic             cke_q;
    logic [REC_W-1:0] rec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
            rec_q <= '0;
        end else begin
            cke_q <= cke;
            if (susp_exit)         rec_q <= REC_W'(T_CKA);
            else if (rec_q != '0)  rec_q <= rec_q - REC_W'(1);
        end
    end

    always_comb begin
        ready = in_idle && cke_q && (rec_q == '0);
        start = ready && cmd_rd;
    end

endmodule

// File: rtl/rdsq_refwatch.sv
module rdsq_refwatch #(
    parameter int SUSP_LIMIT = 16,
    localparam int CNT_W = $clog2(SUSP_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_susp,
    output logic warn
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(SUSP_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!in_susp)     cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb warn = in_susp && (cnt_q == LIM);

endmodule

// File: rtl/sdr_rdburst_susp.sv
module sdr_rdburst_susp #(
    parameter int COL_W = 8,
    parameter int BURST_LEN = 4,
    parameter int T_CKA = 2,
    parameter int SUSP_LIMIT = 16,
    localparam int IDX_W = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cmd_rd,
    input  logic             cas_sel,
    input  logic [COL_W-1:0] col,
    output logic             cmd_ready,
    output logic             word_valid,
    output logic [IDX_W-1:0] word_idx,
    output logic [COL_W-1:0] word_col,
    output logic             suspended,
    output logic             refresh_warn
);

    logic start, in_idle, in_burst, in_susp, susp_exit;

    rdsq_guard #(.T_CKA(T_CKA)) u_guard (
        .clk(clk), .rst_n(rst_n), .cke(cke), .in_idle(in_idle),
        .susp_exit(susp_exit), .cmd_rd(cmd_rd), .ready(cmd_ready), .start(start)
    );

    rdsq_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .cas_sel(cas_sel),
        .idx(word_idx), .in_idle(in_idle), .in_burst(in_burst),
        .in_susp(in_susp), .susp_exit(susp_exit)
    );

    rdsq_colgen #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_colgen (
        .clk(clk), .rst_n(rst_n), .start(start), .col(col),
        .idx(word_idx), .word_col(word_col)
    );

    rdsq_refwatch #(.SUSP_LIMIT(SUSP_LIMIT)) u_refwatch (
        .clk(clk), .rst_n(rst_n), .in_susp(in_susp), .warn(refresh_warn)
    );

    always_comb begin
        word_valid = in_burst;
        suspended  = in_susp;
    end

endmodule

// File: rtl/sdr_rdburst_susp_chk.sv
module sdr_rdburst_susp_chk #(
    parameter int COL_W = 8,
    parameter int BURST_LEN = 4,
    parameter int T_CKA = 2,
    localparam int IDX_W = $clog2(BURST_LEN),
    localparam int RC_W = $clog2(T_CKA + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cmd_ready,
    input logic             word_valid,
    input logic [IDX_W-1:0] word_idx,
    input logic [COL_W-1:0] word_col,
    input logic             suspended,
    input logic             refresh_warn
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);

    logic            armed_q;
    logic [RC_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            since_q <= '0;
        end else if (suspended && cke) begin
            armed_q <= 1'b1;
            since_q <= '0;
        end else if (armed_q && since_q != RC_W'(T_CKA)) begin
            since_q <= since_q + RC_W'(1);
        end
    end

    p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !cke && word_idx != IDX_LAST) |=> suspended);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !cke) |=> (suspended && $stable(word_idx) && $stable(word_col)));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!word_valid && !cmd_ready));

    p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && cke) |=> !suspended);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid)) |->
            (word_idx == $past(word_idx) + IDX_W'(1) &&
             word_col[IDX_W-1:0] == $past(word_col[IDX_W-1:0]) + IDX_W'(1)));

    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && since_q < RC_W'(T_CKA)) |-> !cmd_ready);

    p_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_warn |-> suspended);

endmodule

bind sdr_rdburst_susp sdr_rdburst_susp_chk #(
    .COL_W(COL_W), .BURST_LEN(BURST_LEN), .T_CKA(T_CKA)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_ready(cmd_ready),
    .word_valid(word_valid), .word_idx(word_idx), .word_col(word_col),
    .suspended(suspended), .refresh_warn(refresh_warn)
);

// File: tb/test_sdr_rdburst_susp.sv
`timescale 1ns/1ps
module test_sdr_rdburst_susp;

    localparam int LIMIT = 16;

    logic       clk = 1'b0;
    logic       rst_n, cke, cmd_rd, cas_sel;
    logic [7:0] col;
    logic       cmd_ready, word_valid, suspended, refresh_warn;
    logic [1:0] word_idx;
    logic [7:0] word_col;

    int n_tests = 0;
    int n_fail  = 0;
    int bad_overlap = 0;
    logic [7:0] got[$];

    always #4 clk = ~clk;

    sdr_rdburst_susp i_sdr_rdburst_susp (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_rd(cmd_rd), .cas_sel(cas_sel),
        .col(col), .cmd_ready(cmd_ready), .word_valid(word_valid),
        .word_idx(word_idx), .word_col(word_col), .suspended(suspended),
        .refresh_warn(refresh_warn)
    );

    always @(negedge clk) begin
        if (word_valid) got.push_back(word_col);
        if (word_valid && suspended) bad_overlap++;
    end

    function automatic logic [7:0] exp_col(input logic [7:0] s, input int k);
        return {s[7:2], 2'(s[1:0] + 2'(k))};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic issue(input logic [7:0] c, input logic sel);
        cmd_rd = 1'b1; col = c; cas_sel = sel;
        step();
        cmd_rd = 1'b0;
    endtask

    task automatic check_word(input string req, input logic [7:0] s, input int k);
        chk(req, "word_valid", int'(word_valid), 1);
        chk(req, "word_idx", int'(word_idx), k);
        chk(req, "word_col", int'(word_col), int'(exp_col(s, k)));
    endtask

    task automatic plain_read(input logic [7:0] c, input logic sel);
        int lat;
        lat = sel ? 3 : 2;
        issue(c, sel);
        for (int j = 0; j < lat - 1; j++) begin
            chk("R2", "valid during latency", int'(word_valid), 0);
            step();
        end
        for (int k = 0; k < 4; k++) begin
            check_word("R3", c, k);
            step();
        end
        chk("R3", "valid after burst", int'(word_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; cke = 1'b1; cmd_rd = 1'b0; cas_sel = 1'b0; col = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "word_valid", int'(word_valid), 0);
        chk("R1", "suspended", int'(suspended), 0);
        chk("R1", "refresh_warn", int'(refresh_warn), 0);
        chk("R1", "cmd_ready", int'(cmd_ready), 1);

        // R2/R3 plain bursts at both latencies
        plain_read(8'h25, 1'b0);
        step();
        plain_read(8'hB3, 1'b1);
        step();

        // R4/R5/R6 suspend in mid burst, commands during suspend ignored
        issue(8'h42, 1'b0);
        step();
        check_word("R3", 8'h42, 0);
        cke = 1'b0;
        step();
        chk("R4", "suspended after entry", int'(suspended), 1);
        chk("R5", "valid while suspended", int'(word_valid), 0);
        chk("R5", "ready while suspended", int'(cmd_ready), 0);
        cmd_rd = 1'b1; col = 8'hFF; cas_sel = 1'b1;
        step();
        chk("R4", "held word_idx", int'(word_idx), 1);
        chk("R4", "held word_col", int'(word_col), int'(exp_col(8'h42, 1)));
        cke = 1'b1; cmd_rd = 1'b0;
        step();
        chk("R6", "suspended after exit", int'(suspended), 0);
        check_word("R6", 8'h42, 1);
        step(); check_word("R6", 8'h42, 2);
        step(); check_word("R6", 8'h42, 3);
        step();
        chk("R5", "no burst from ignored command", int'(word_valid), 0);
        chk("R9", "ready after burst", int'(cmd_ready), 1);
        step(); step();
        chk("R5", "still idle", int'(word_valid), 0);

        // R4/R6 suspend inside latency (latency 3), three suspended edges
        issue(8'h07, 1'b1);
        cke = 1'b0;
        step();
        chk("R4", "suspended in latency", int'(suspended), 1);
        step(); step();
        cke = 1'b1;
        step();
        chk("R6", "latency resumes, no word yet", int'(word_valid), 0);
        step();
        check_word("R6", 8'h07, 0);
        for (int k = 1; k < 4; k++) begin
            step();
            check_word("R6", 8'h07, k);
        end
        step(); step();

        // R7 recovery lockout with suspend on the last word
        issue(8'h10, 1'b0);
        step(); step(); step();
        check_word("R3", 8'h10, 2);
        cke = 1'b0;
        step();
        chk("R4", "suspended before last word", int'(suspended), 1);
        cke = 1'b1;
        step();
        check_word("R6", 8'h10, 3);
        step();
        chk("R7", "ready inside lockout", int'(cmd_ready), 0);
        cmd_rd = 1'b1; col = 8'h30;
        step();
        chk("R7", "ready after lockout", int'(cmd_ready), 1);
        cmd_rd = 1'b0;
        step(); step();
        chk("R7", "locked command started no burst", int'(word_valid), 0);

        // R10 cke low on the last word: no suspend, ready waits for cke
        issue(8'h00, 1'b0);
        step(); step(); step(); step();
        check_word("R3", 8'h00, 3);
        cke = 1'b0;
        step();
        chk("R10", "no suspend at burst end", int'(suspended), 0);
        chk("R10", "idle after last word", int'(word_valid), 0);
        chk("R9", "ready with cke low", int'(cmd_ready), 0);
        cke = 1'b1;
        step();
        chk("R9", "ready once cke high", int'(cmd_ready), 1);

        // R9 command held during a burst is ignored
        got.delete();
        issue(8'h5E, 1'b0);
        cmd_rd = 1'b1; col = 8'h81;
        step(); step(); step(); step();
        cmd_rd = 1'b0;
        step(); step(); step();
        chk("R9", "words with busy command", int'(got.size()), 4);
        for (int k = 0; k < 4 && k < got.size(); k++)
            chk("R9", "column with busy command", int'(got[k]), int'(exp_col(8'h5E, k)));

        // R8 refresh budget warning
        issue(8'h99, 1'b0);
        step();
        cke = 1'b0;
        step();
        for (int k = 0; k < LIMIT; k++) begin
            if (k == 0 || k == LIMIT - 1)
                chk("R8", "warn before limit", int'(refresh_warn), 0);
            step();
        end
        chk("R8", "warn at limit", int'(refresh_warn), 1);
        chk("R8", "still suspended", int'(suspended), 1);
        cke = 1'b1;
        step();
        chk("R8", "warn after exit", int'(refresh_warn), 0);
        step(); step(); step(); step();

        // random reads with random suspends and junk commands
        for (int t = 0; t < 150; t++) begin
            logic [7:0] s;
            logic       sel;
            int         guard;
            cke = 1'b1;
            guard = 0;
            while (!cmd_ready && guard < 20) begin step(); guard++; end
            s = 8'($urandom);
            sel = 1'($urandom);
            got.delete();
            issue(s, sel);
            for (int c = 0; c < 80; c++) begin
                cke = ($urandom % 4) != 0;
                if (suspended) begin
                    cmd_rd = 1'($urandom); col = 8'($urandom); cas_sel = 1'($urandom);
                end else begin
                    cmd_rd = 1'b0;
                end
                step();
                if (got.size() >= 4 && !word_valid && !suspended) break;
            end
            cmd_rd = 1'b0; cke = 1'b1;
            step(); step();
            chk("R6", "random burst word count", int'(got.size()), 4);
            for (int k = 0; k < 4 && k < got.size(); k++)
                if (got[k] != exp_col(s, k))
                    chk("R3", "random burst column", int'(got[k]), int'(exp_col(s, k)));
        end
        chk("R5", "valid seen while suspended", bad_overlap, 0);
        summary();
    end

endmodule